// File: doc/BRIEF.md
# Glitch-Rejecting Input Filter Bank

A bank of digital input filters, one per pin, that removes short glitches from already-synchronous input levels before they reach the rest of the chip. Every filter in the bank shares one programmable length and one tick source, and each filter has its own enable bit. A filter only moves its output to a new level after its input has stayed at that level for more than the programmed number of filter ticks. Any excursion of that length or shorter is absorbed.

The tick source is either every system clock cycle or a slow, low-power tick. The slow tick arrives as a one-cycle-wide enable that is synchronous to the system clock. Software sets the bank up through a small register port with a synchronous write and a combinational read. The length and tick-source settings are frozen while any filter is enabled. A disabled filter drives zero, and it starts counting from scratch when it is enabled again.

Top module: `glitch_filter_bank`

## Requirements
- R1: After reset, every register reads zero and every filter output is zero.
- R2: The enable register is at offset 0xC0, where bit i enables pin i. The tick-source register is at 0xC4, bit 0. The length register is at 0xC8, bits [4:0]. Unused bits and unmapped offsets read zero. A write takes effect at the clock edge that samples it.
- R3: While a pin's enable bit is clear, its output is zero from the next clock edge on, whatever its input does.
- R4: With tick source 0, every cycle is a tick. An output takes a new input level at the (LEN+1)-th consecutive rising edge that samples that level.
- R5: An input excursion that lasts LEN ticks or fewer leaves the output unchanged.
- R6: With LEN = 0, the output follows the input at the next tick, so a single-cycle pulse passes.
- R7: With tick source 1, only cycles with slow_tick high advance a filter. In cycles without a tick, every output holds its value.
- R8: Whenever the input matches the output, that filter's count restarts from zero. A later excursion then needs the full LEN+1 ticks again.
- R9: Writes to the length or tick-source register are ignored while any enable bit is set. The enable register can always be written.
- R10: Each filter depends only on its own pin and its own enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle low-power tick enable, used when tick source is 1 |
| pin_in | input | 32 | Synchronous pin levels to be filtered |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register offset for read and write |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for addr (combinational) |
| filt_out | output | 32 | Filtered pin levels |

## Verification
A filtered result is due at the (LEN+1)-th rising edge that samples the new level. That edge is counted from the first edge on which the pin differs from the output, or from the first slow tick when tick source 1 is selected. Register writes are due one edge after the strobe, and reads are valid in the same cycle. The bench drives every input at a falling edge, lets exactly the counted number of rising edges pass, and samples at the next falling edge. Each glitch case is checked at the edge where a wrongly sized filter would already have switched.

// File: rtl/gfb_pkg.sv
package gfb_pkg;

  // Register selected by the current offset.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_SRC  = 2'd2,
    SEL_LEN  = 2'd3
  } reg_sel_e;

  // Tick source encodings held in the source register.
  localparam logic SRC_SYSCLK = 1'b0;
  localparam logic SRC_SLOW   = 1'b1;

endpackage

// File: rtl/gfb_regs.sv
module gfb_regs
  import gfb_pkg::*;
#(
  parameter int                N_PINS  = 32,
  parameter int                LEN_W   = 5,
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 32,
  parameter logic [ADDR_W-1:0] OFF_EN  = 8'hC0,
  parameter logic [ADDR_W-1:0] OFF_SRC = 8'hC4,
  parameter logic [ADDR_W-1:0] OFF_LEN = 8'hC8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_PINS-1:0] en_o,
  output logic              src_o,
  output logic [LEN_W-1:0]  len_o
);

  reg_sel_e          sel;
  logic [N_PINS-1:0] en_q,  en_d;
  logic              src_q, src_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              locked;
  logic              wdata_unused;

  assign wdata_unused = ^wdata;

  // Offset decode
  always_comb begin
    if (addr == OFF_EN)       sel = SEL_EN;
    else if (addr == OFF_SRC) sel = SEL_SRC;
    else if (addr == OFF_LEN) sel = SEL_LEN;
    else                      sel = SEL_NONE;
  end

  // Shared settings freeze while any filter runs
  assign locked = |en_q;

  // Next state
  always_comb begin
    en_d  = en_q;
    src_d = src_q;
    len_d = len_q;
    if (wr_en) begin
      if (sel == SEL_EN)                en_d  = wdata[N_PINS-1:0];
      if (sel == SEL_SRC && !locked)    src_d = wdata[0];
      if (sel == SEL_LEN && !locked)    len_d = wdata[LEN_W-1:0];
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      src_q <= SRC_SYSCLK;
      len_q <= '0;
    end else begin
      en_q  <= en_d;
      src_q <= src_d;
      len_q <= len_d;
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    case (sel)
      SEL_EN:  rdata[N_PINS-1:0] = en_q;
      SEL_SRC: rdata[0]          = src_q;
      SEL_LEN: rdata[LEN_W-1:0]  = len_q;
      default: rdata             = '0;
    endcase
  end

  assign en_o  = en_q;
  assign src_o = src_q;
  assign len_o = len_q;

  // R9: frozen settings while any filter is enabled
  a_r9_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_q) |=> $stable(len_q));
  a_r9_src_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_q) |=> $stable(src_q));

endmodule

// File: rtl/gfb_tick_sel.sv
module gfb_tick_sel
  import gfb_pkg::*;
(
  input  logic src,
  input  logic slow_tick,
  output logic tick
);

  // Source 0: every cycle counts; source 1: only slow ticks count.
  always_comb begin
    if (src == SRC_SLOW) tick = slow_tick;
    else                 tick = 1'b1;
  end

endmodule

// File: rtl/gfb_cell.sv
module gfb_cell #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  input  logic             din,
  output logic             dout
);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic             differs;
  logic             expire;

  assign differs = (din != out_q);
  assign expire  = (cnt_q >= len);

  // Next state
  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (!en) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else if (!differs) begin
      cnt_d = '0;
    end else if (tick) begin
      if (expire) begin
        out_d = din;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign dout = out_q;

  // R3: disabled filter drives zero from the next edge
  a_r3_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (dout == 1'b0));
  // R8: matching input never moves the output
  a_r8_match_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && din == dout) |=> $stable(dout));
  // R7: no tick, no change
  a_r7_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(dout));
  // R5: count never passes the programmed length
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= len));

endmodule

// File: rtl/glitch_filter_bank.sv
module glitch_filter_bank #(
  parameter int                N_PINS  = 32,
  parameter int                LEN_W   = 5,
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 32,
  parameter logic [ADDR_W-1:0] OFF_EN  = 8'hC0,
  parameter logic [ADDR_W-1:0] OFF_SRC = 8'hC4,
  parameter logic [ADDR_W-1:0] OFF_LEN = 8'hC8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic [N_PINS-1:0] pin_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_PINS-1:0] filt_out
);

  logic [N_PINS-1:0] en_w;
  logic              src_w;
  logic [LEN_W-1:0]  len_w;
  logic              tick_w;

  gfb_regs #(
    .N_PINS (N_PINS),
    .LEN_W  (LEN_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFF_EN (OFF_EN),
    .OFF_SRC(OFF_SRC),
    .OFF_LEN(OFF_LEN)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .en_o  (en_w),
    .src_o (src_w),
    .len_o (len_w)
  );

  gfb_tick_sel u_tick (
    .src       (src_w),
    .slow_tick (slow_tick),
    .tick      (tick_w)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_lane
    gfb_cell #(.LEN_W(LEN_W)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en_w[i]),
      .tick (tick_w),
      .len  (len_w),
      .din  (pin_in[i]),
      .dout (filt_out[i])
    );
  end

endmodule

// File: tb/test_glitch_filter_bank.sv
module test_glitch_filter_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        slow_tick;
  logic [31:0] pin_in;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [31:0] filt_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  glitch_filter_bank i_glitch_filter_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_tick(slow_tick),
    .pin_in   (pin_in),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .filt_out (filt_out)
  );

  // {pins, expected output after the edge}, LEN=2, source 0, all enabled
  localparam logic [63:0] VEC [0:20] = '{
    {32'h01, 32'h00}, {32'h01, 32'h00}, {32'h01, 32'h01}, {32'h03, 32'h01},
    {32'h01, 32'h01}, {32'h03, 32'h01}, {32'h03, 32'h01}, {32'h01, 32'h01},
    {32'h00, 32'h01}, {32'h01, 32'h01}, {32'h00, 32'h01}, {32'h00, 32'h01},
    {32'h00, 32'h00}, {32'h80, 32'h00}, {32'h80, 32'h00}, {32'h81, 32'h80},
    {32'h81, 32'h80}, {32'h81, 32'h81}, {32'h00, 32'h81}, {32'h00, 32'h81},
    {32'h00, 32'h00}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic step(input logic [31:0] p, input logic t);
    pin_in = p; slow_tick = t;
    @(posedge clk); @(negedge clk);
    slow_tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; slow_tick = 1'b0; pin_in = '0;
    wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    pin_in = 32'hFFFF_FFFF;
    #1;
    chk("R1 outputs in reset", filt_out, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    pin_in = '0;

    // R1 / R2: reset values and mapping
    rd_chk("R1 enable reset", 8'hC0, 32'h0);
    rd_chk("R1 source reset", 8'hC4, 32'h0);
    rd_chk("R1 length reset", 8'hC8, 32'h0);
    rd_chk("R2 unmapped offset", 8'hCC, 32'h0);
    @(negedge clk);
    wr(8'hC8, 32'hFFFF_FFE2);
    rd_chk("R2 length bits [4:0]", 8'hC8, 32'h2);
    wr(8'hC4, 32'hFFFF_FFFE);
    rd_chk("R2 source bit 0", 8'hC4, 32'h0);
    wr(8'hC0, 32'hFFFF_FFFF);
    rd_chk("R2 enable readback", 8'hC0, 32'hFFFF_FFFF);
    @(negedge clk);

    // R4 R5 R8 R10: table walk, LEN=2
    for (int k = 0; k <= 20; k++) begin
      step(VEC[k][63:32], 1'b0);
      chk($sformatf("R4/R5/R8 vector %0d", k), filt_out, VEC[k][31:0]);
    end

    // R9: shared settings locked while enabled
    wr(8'hC8, 32'h5);
    rd_chk("R9 length write ignored", 8'hC8, 32'h2);
    wr(8'hC4, 32'h1);
    rd_chk("R9 source write ignored", 8'hC4, 32'h0);
    @(negedge clk);

    // R3 R10: disabling lanes 4..7 only
    step(32'hFF, 1'b0);
    step(32'hFF, 1'b0);
    step(32'hFF, 1'b0);
    chk("R4 byte passes after LEN+1", filt_out, 32'hFF);
    wr(8'hC0, 32'hFFFF_FF0F);
    step(32'hFF, 1'b0);
    chk("R3 R10 disabled lanes zero", filt_out, 32'h0F);
    repeat (4) step(32'hFF, 1'b0);
    chk("R3 disabled lanes stay zero", filt_out, 32'h0F);

    // R6: LEN=0
    pin_in = '0;
    wr(8'hC0, 32'h0);
    wr(8'hC8, 32'h0);
    rd_chk("R9 length writable when idle", 8'hC8, 32'h0);
    @(negedge clk);
    wr(8'hC0, 32'hFFFF_FFFF);
    step(32'h05, 1'b0);
    chk("R6 single-cycle pulse passes", filt_out, 32'h05);
    step(32'h00, 1'b0);
    chk("R6 follows next tick", filt_out, 32'h00);

    // R7: slow tick source, LEN=1
    wr(8'hC0, 32'h0);
    wr(8'hC8, 32'h1);
    wr(8'hC4, 32'h1);
    rd_chk("R7 source set", 8'hC4, 32'h1);
    @(negedge clk);
    wr(8'hC0, 32'hFFFF_FFFF);
    repeat (5) step(32'h01, 1'b0);
    chk("R7 no tick no change", filt_out, 32'h0);
    step(32'h01, 1'b1);
    chk("R7 first tick counts only", filt_out, 32'h0);
    repeat (3) step(32'h01, 1'b0);
    chk("R7 idle cycles hold", filt_out, 32'h0);
    step(32'h01, 1'b1);
    chk("R7 second tick passes", filt_out, 32'h01);
    repeat (3) step(32'h00, 1'b0);
    chk("R7 low without ticks held", filt_out, 32'h01);
    step(32'h01, 1'b1);
    step(32'h00, 1'b1);
    chk("R8 count restarts", filt_out, 32'h01);
    step(32'h01, 1'b0);
    step(32'h00, 1'b1);
    chk("R8 match reset before tick", filt_out, 32'h01);
    step(32'h00, 1'b1);
    chk("R7 low passes after LEN+1 ticks", filt_out, 32'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule